// File: doc/BRIEF.md
# IDE Configuration Register Unlock Bank

This block sits on the command-block I/O decode of one IDE channel. It guards a hidden bank of timing and control registers. After reset the block is locked. Every access on the I/O bus passes straight through to the task-file registers, and read data comes back from the task-file. A short access sequence unlocks the block: two 16-bit reads at offset 1, then a byte write of 0x03 at offset 2. From then on the same offsets address the configuration bank and the task-file sees no strobes. A byte write of 0x83 at offset 2 locks the block again.

Inside the bank, the misc byte does two jobs. Its low bit picks the device whose read-timing and write-timing bytes are written at offsets 0 and 1. Its upper bits hold the shared address-setup value. The strap byte at offset 5 mirrors an input pin; its bit 0 gives the bus clock (0 for 33 MHz, 1 for 25 MHz). Programmed values are staged first. Writing 0x85 to the control byte commits them to the output ports that feed a downstream timing generator, so that timing set 0 drives device 0 and timing set 1 drives device 1.

The sequence detector is a four-state machine:
- ST_LOCKED (idle). A 16-bit read at offset 1 moves it to ST_SAW_RD1.
- ST_SAW_RD1. A second such read moves it to ST_SAW_RD2.
- ST_SAW_RD2. A byte write of 0x03 at offset 2 moves it to ST_UNLOCKED. A further 16-bit read at offset 1 keeps it in ST_SAW_RD2.
- In ST_SAW_RD1 and ST_SAW_RD2, any other access returns it to ST_LOCKED. Cycles with no access leave the state unchanged.
- ST_UNLOCKED. A byte write of 0x83 at offset 2 returns it to ST_LOCKED.

Top module: `ide_cfg_unlock_top`

## Requirements
- R1: After reset the block is locked, the misc byte and the control byte read zero, and every timing output and the address-setup output are zero.
- R2: While locked, io_rd and io_wr drive tf_rd and tf_wr in the same cycle. io_addr, io_word and io_wdata are forwarded unchanged on tf_addr, tf_word and tf_wdata, and io_rdata equals tf_rdata.
- R3: The block unlocks on the clock edge that ends this sequence: two 16-bit reads (io_word=1) at offset 1, then a byte write (io_word=0) with low data byte 0x03 at offset 2. The three accesses of the sequence are still passed to the task-file.
- R4: In ST_SAW_RD1 and ST_SAW_RD2, any access that is not the next step of the sequence returns the detector to idle. This covers byte reads at offset 1, accesses at other offsets, a 16-bit write at offset 2, and a write at offset 2 whose value is not 0x03. A third 16-bit read at offset 1 keeps the detector waiting for the write. Idle cycles break nothing.
- R5: While unlocked, tf_rd and tf_wr stay low. io_rdata returns the bank register at io_addr in bits 7:0, with bits 15:8 zero.
- R6: While unlocked, a byte write of 0x83 at offset 2 locks the block from the next cycle on. That write does not reach the task-file.
- R7: Offset 6 is the misc byte. It is read and written as a whole byte. Its bit 0 selects device 0 or device 1, and its bits 7:1 are the address-setup value.
- R8: Writes at offset 0 (read timing) and offset 1 (write timing) land in the staged timing set of the device selected by misc bit 0. Reads at those offsets return that device's staged value.
- R9: Offset 5 reads strap_in, whose bit 0 reports the bus clock (0 = 33 MHz, 1 = 25 MHz). Writes at offset 5 change nothing.
- R10: Offset 3 is the control byte and reads back the last value written. Writing 0x85 copies both staged timing sets and the staged misc byte to the outputs on that clock edge. Writing any other value leaves the outputs unchanged.
- R11: Offsets 2, 4 and 7 read as zero while unlocked. Writes to them change no register.
- R12: Bank contents are kept across relock and a later unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Command-block offset |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data (task-file or bank) |
| tf_addr | output | 3 | Task-file offset |
| tf_word | output | 1 | Task-file access size |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data |
| strap_in | input | 8 | Strap byte; bit 0 = bus clock select |
| dev_rd_tmg | output | 16 | Committed read timing, device n in bits 8n+7:8n |
| dev_wr_tmg | output | 16 | Committed write timing, device n in bits 8n+7:8n |
| addr_setup | output | 7 | Committed shared address-setup value (misc bits 7:1) |

## Verification
The hardest situations to reach from the ports are the near misses of the unlock sequence. These include a break after one or after two reads, a third read before the key write, a key write of the wrong size or the wrong value, and a relock write attempted while still locked. Directed runs step through each of these. After each one, a read shows which side answered, the task-file strobe or bank data, and so reveals the detector state. Random traffic then mixes key-valued writes, offset-1 reads and bank programming in any order. A bench model predicts the lock state, the read data, the strobes and the committed outputs after every access.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_SAW_RD1  = 2'd1,
        ST_SAW_RD2  = 2'd2,
        ST_UNLOCKED = 2'd3
    } ulk_state_t;

    // Bank offsets (fixed by the register decode)
    localparam int OFS_RD_TMG = 0;
    localparam int OFS_WR_TMG = 1;
    localparam int OFS_KEY    = 2;
    localparam int OFS_CTRL   = 3;
    localparam int OFS_STRAP  = 5;
    localparam int OFS_MISC   = 6;

    // Sequence probe offset for the two word reads
    localparam int OFS_PROBE  = 1;

    localparam logic [7:0] KEY_UNLOCK  = 8'h03;
    localparam logic [7:0] KEY_RELOCK  = 8'h83;
    localparam logic [7:0] CTRL_COMMIT = 8'h85;

endpackage

// File: rtl/ide_unlock_fsm.sv
module ide_unlock_fsm
    import ide_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_byte,
    output logic              locked
);

    localparam logic [ADDR_W-1:0] A_PROBE = ADDR_W'(OFS_PROBE);
    localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);

    ulk_state_t state, state_nx;

    logic any_acc, probe_rd, key_open, key_close;

    always_comb begin
        any_acc   = acc_rd | acc_wr;
        probe_rd  = acc_rd & acc_word & (acc_addr == A_PROBE);
        key_open  = acc_wr & ~acc_word & (acc_addr == A_KEY) & (acc_byte == KEY_UNLOCK);
        key_close = acc_wr & ~acc_word & (acc_addr == A_KEY) & (acc_byte == KEY_RELOCK);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: begin
                if (probe_rd) state_nx = ST_SAW_RD1;
            end
            ST_SAW_RD1: begin
                if (probe_rd)     state_nx = ST_SAW_RD2;
                else if (any_acc) state_nx = ST_LOCKED;
            end
            ST_SAW_RD2: begin
                if (key_open)      state_nx = ST_UNLOCKED;
                else if (probe_rd) state_nx = ST_SAW_RD2;
                else if (any_acc)  state_nx = ST_LOCKED;
            end
            ST_UNLOCKED: begin
                if (key_close) state_nx = ST_LOCKED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        locked = (state != ST_UNLOCKED);
    end

    // R3: the key write after two probe reads opens the bank
    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAW_RD2 && key_open) |=> !locked);

    // R4: a foreign access after one probe read returns to idle
    assert_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAW_RD1 && any_acc && !probe_rd) |=> (state == ST_LOCKED));

    // R6: the relock write closes the bank
    assert_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNLOCKED && key_close) |=> locked);

    // R1: no unlock without passing through the second probe state
    assert_no_shortcut_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_SAW_RD2 && $past(state) != ST_UNLOCKED) |-> locked);

endmodule

// File: rtl/ide_cfg_bank.sv
module ide_cfg_bank
    import ide_cfg_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int TW      = 8,
    parameter int NUM_DEV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [TW-1:0]         wdata,
    input  logic [TW-1:0]         strap_in,
    output logic [TW-1:0]         rdata,
    output logic [NUM_DEV*TW-1:0] rd_tmg_o,
    output logic [NUM_DEV*TW-1:0] wr_tmg_o,
    output logic [TW-2:0]         addr_setup_o
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    localparam logic [ADDR_W-1:0] A_RD    = ADDR_W'(OFS_RD_TMG);
    localparam logic [ADDR_W-1:0] A_WR    = ADDR_W'(OFS_WR_TMG);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STRAP = ADDR_W'(OFS_STRAP);
    localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(OFS_MISC);

    logic [TW-1:0]         misc_q, misc_cm_q, ctrl_q;
    logic [NUM_DEV*TW-1:0] stg_rd_flat, stg_wr_flat;
    logic [SEL_W-1:0]      sel;
    logic                  commit;

    always_comb begin
        sel    = misc_q[SEL_W-1:0];
        commit = wr_en & (addr == A_CTRL) & (wdata == CTRL_COMMIT);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : gen_dev
            logic [TW-1:0] stg_rd, stg_wr, cm_rd, cm_wr;
            logic          hit;
            always_comb hit = (sel == SEL_W'(g));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_rd <= '0;
                    stg_wr <= '0;
                    cm_rd  <= '0;
                    cm_wr  <= '0;
                end else begin
                    if (wr_en && hit && addr == A_RD) stg_rd <= wdata;
                    if (wr_en && hit && addr == A_WR) stg_wr <= wdata;
                    if (commit) begin
                        cm_rd <= stg_rd;
                        cm_wr <= stg_wr;
                    end
                end
            end
            assign stg_rd_flat[g*TW +: TW] = stg_rd;
            assign stg_wr_flat[g*TW +: TW] = stg_wr;
            assign rd_tmg_o[g*TW +: TW]    = cm_rd;
            assign wr_tmg_o[g*TW +: TW]    = cm_wr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q    <= '0;
            misc_cm_q <= '0;
            ctrl_q    <= '0;
        end else begin
            if (wr_en && addr == A_MISC) misc_q <= wdata;
            if (wr_en && addr == A_CTRL) ctrl_q <= wdata;
            if (commit)                  misc_cm_q <= misc_q;
        end
    end

    always_comb begin
        unique case (addr)
            A_RD:    rdata = stg_rd_flat[sel*TW +: TW];
            A_WR:    rdata = stg_wr_flat[sel*TW +: TW];
            A_CTRL:  rdata = ctrl_q;
            A_STRAP: rdata = strap_in;
            A_MISC:  rdata = misc_q;
            default: rdata = '0;
        endcase
    end

    assign addr_setup_o = misc_cm_q[TW-1:1];

    // R10: commit copies the staged sets onto the outputs
    assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (rd_tmg_o == $past(stg_rd_flat)) && (wr_tmg_o == $past(stg_wr_flat))
                   && (addr_setup_o == $past(misc_q[TW-1:1])));

    // R10: outputs only move on a commit
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rd_tmg_o) && $stable(wr_tmg_o) && $stable(addr_setup_o));

    // R11 / R9: writes to unimplemented or read-only offsets touch nothing
    assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != A_RD && addr != A_WR && addr != A_CTRL && addr != A_MISC)
        |=> $stable(stg_rd_flat) && $stable(stg_wr_flat) && $stable(misc_q) && $stable(ctrl_q));

    // R8: a timing write reaches only the selected device set
    assert_steer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RD) |=> (stg_rd_flat[$past(sel)*TW +: TW] == $past(wdata))
                                    && $stable(stg_wr_flat));

endmodule

// File: rtl/ide_cfg_unlock_top.sv
module ide_cfg_unlock_top #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16,
    parameter int TW      = 8,
    parameter int NUM_DEV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_word,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [DATA_W-1:0]     io_wdata,
    output logic [DATA_W-1:0]     io_rdata,
    output logic [ADDR_W-1:0]     tf_addr,
    output logic                  tf_word,
    output logic                  tf_rd,
    output logic                  tf_wr,
    output logic [DATA_W-1:0]     tf_wdata,
    input  logic [DATA_W-1:0]     tf_rdata,
    input  logic [TW-1:0]         strap_in,
    output logic [NUM_DEV*TW-1:0] dev_rd_tmg,
    output logic [NUM_DEV*TW-1:0] dev_wr_tmg,
    output logic [TW-2:0]         addr_setup
);

    logic          locked;
    logic          bank_wr;
    logic [TW-1:0] bank_rdata;

    ide_unlock_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (io_rd),
        .acc_wr   (io_wr),
        .acc_word (io_word),
        .acc_addr (io_addr),
        .acc_byte (io_wdata[7:0]),
        .locked   (locked)
    );

    assign bank_wr = io_wr & ~locked;

    ide_cfg_bank #(.ADDR_W(ADDR_W), .TW(TW), .NUM_DEV(NUM_DEV)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bank_wr),
        .addr         (io_addr),
        .wdata        (io_wdata[TW-1:0]),
        .strap_in     (strap_in),
        .rdata        (bank_rdata),
        .rd_tmg_o     (dev_rd_tmg),
        .wr_tmg_o     (dev_wr_tmg),
        .addr_setup_o (addr_setup)
    );

    always_comb begin
        tf_addr  = io_addr;
        tf_word  = io_word;
        tf_wdata = io_wdata;
        tf_rd    = io_rd & locked;
        tf_wr    = io_wr & locked;
        io_rdata = locked ? tf_rdata : {{(DATA_W-TW){1'b0}}, bank_rdata};
    end

    // R5: the task-file never sees a strobe while the bank is open
    assert_tf_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !tf_rd && !tf_wr);

    // R2: while locked every strobe reaches the task-file
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && (io_rd || io_wr)) |-> (tf_rd || tf_wr));

endmodule

// File: tb/ide_cfg_unlock_top_tb_top.sv
module ide_cfg_unlock_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  io_addr = '0;
    logic        io_word = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [15:0] io_wdata = '0, io_rdata, tf_wdata, tf_rdata = '0;
    logic [2:0]  tf_addr;
    logic        tf_word, tf_rd, tf_wr;
    logic [7:0]  strap_in = 8'h00;
    logic [15:0] dev_rd_tmg, dev_wr_tmg;
    logic [6:0]  addr_setup;

    int n_chk = 0, n_err = 0;

    // bench model
    int         m_seq = 0;
    logic [7:0] m_srd [2];
    logic [7:0] m_swr [2];
    logic [7:0] m_crd [2];
    logic [7:0] m_cwr [2];
    logic [7:0] m_misc = 0, m_mcm = 0, m_ctrl = 0;

    always #4 clk = ~clk;

    ide_cfg_unlock_top dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_word(io_word),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .tf_addr(tf_addr), .tf_word(tf_word), .tf_rd(tf_rd), .tf_wr(tf_wr),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .strap_in(strap_in),
        .dev_rd_tmg(dev_rd_tmg), .dev_wr_tmg(dev_wr_tmg), .addr_setup(addr_setup)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bank_exp(input logic [2:0] a);
        case (a)
            3'd0: return m_srd[m_misc[0]];
            3'd1: return m_swr[m_misc[0]];
            3'd3: return m_ctrl;
            3'd5: return strap_in;
            3'd6: return m_misc;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step(input bit rd, input bit wr, input bit word,
                              input logic [2:0] a, input logic [7:0] d);
        bit probe, kopen;
        probe = rd && word && a == 3'd1;
        kopen = wr && !word && a == 3'd2 && d == 8'h03;
        if (!rd && !wr) return;
        case (m_seq)
            0: m_seq = probe ? 1 : 0;
            1: m_seq = probe ? 2 : 0;
            2: m_seq = kopen ? 3 : (probe ? 2 : 0);
            default: begin
                if (wr) begin
                    case (a)
                        3'd0: m_srd[m_misc[0]] = d;
                        3'd1: m_swr[m_misc[0]] = d;
                        3'd3: begin
                            m_ctrl = d;
                            if (d == 8'h85) begin
                                m_crd[0] = m_srd[0]; m_crd[1] = m_srd[1];
                                m_cwr[0] = m_swr[0]; m_cwr[1] = m_swr[1];
                                m_mcm = m_misc;
                            end
                        end
                        3'd6: m_misc = d;
                        default: ;
                    endcase
                    if (!word && a == 3'd2 && d == 8'h83) m_seq = 0;
                end
            end
        endcase
    endtask

    task automatic check_outs(input string req);
        chk(req, {16'h0, dev_rd_tmg}, {16'h0, m_crd[1], m_crd[0]});
        chk(req, {16'h0, dev_wr_tmg}, {16'h0, m_cwr[1], m_cwr[0]});
        chk(req, {25'h0, addr_setup}, {25'h0, m_mcm[7:1]});
    endtask

    task automatic acc(input bit rd, input bit wr, input bit word, input logic [2:0] a,
                       input logic [15:0] d, input string req);
        bit lk;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_word = word; io_addr = a; io_wdata = d;
        tf_rdata = 16'($urandom);
        #1;
        lk = (m_seq != 3);
        chk(req, {31'h0, tf_rd}, {31'h0, rd & lk});
        chk(req, {31'h0, tf_wr}, {31'h0, wr & lk});
        if (lk) chk(req, {12'h0, tf_addr, tf_word, tf_wdata}, {12'h0, a, word, d});
        if (rd) chk(req, {16'h0, io_rdata}, lk ? {16'h0, tf_rdata} : {24'h0, bank_exp(a)});
        @(posedge clk);
        model_step(rd, wr, word, a, d[7:0]);
        #1;
        io_rd = 1'b0; io_wr = 1'b0;
        check_outs(req);
    endtask

    task automatic unlock(input string req);
        acc(1, 0, 1, 3'd1, 16'h0, req);
        acc(1, 0, 1, 3'd1, 16'h0, req);
        acc(0, 1, 0, 3'd2, 16'h0003, req);
    endtask

    task automatic lockst(input string req, input int exp);
        // a read of offset 6 shows which side answers
        acc(1, 0, 0, 3'd6, 16'h0, req);
        chk(req, m_seq == 3 ? 32'd1 : 32'd0, exp[31:0]);
    endtask

    initial begin
        #1_600_000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_srd[i] = 0; m_swr[i] = 0; m_crd[i] = 0; m_cwr[i] = 0;
        end
        void'($urandom(32'h1DEC0F1));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check_outs("R1");
        acc(1, 0, 1, 3'd6, 16'h0, "R1");
        // R2: pass-through while locked
        acc(0, 1, 1, 3'd4, 16'hBEEF, "R2");
        acc(1, 0, 0, 3'd7, 16'h0, "R2");
        // R3: unlock
        unlock("R3");
        lockst("R3", 1);
        acc(1, 0, 0, 3'd6, 16'h0, "R5");
        // R7/R8: program device 0 then device 1
        acc(0, 1, 0, 3'd6, 16'h0030, "R7");
        acc(0, 1, 0, 3'd0, 16'h0059, "R8");
        acc(0, 1, 0, 3'd1, 16'h0046, "R8");
        acc(0, 1, 0, 3'd6, 16'h0021, "R7");
        acc(0, 1, 0, 3'd0, 16'h0046, "R8");
        acc(0, 1, 0, 3'd1, 16'h0032, "R8");
        acc(1, 0, 0, 3'd0, 16'h0, "R8");
        acc(0, 1, 0, 3'd6, 16'h0020, "R7");
        acc(1, 0, 0, 3'd0, 16'h0, "R8");
        acc(1, 0, 0, 3'd1, 16'h0, "R8");
        // R10: non-commit then commit
        acc(0, 1, 0, 3'd3, 16'h0011, "R10");
        acc(1, 0, 0, 3'd3, 16'h0, "R10");
        acc(0, 1, 0, 3'd3, 16'h0085, "R10");
        chk("R10", {16'h0, dev_rd_tmg}, 32'h4659);
        // R9: strap
        strap_in = 8'h01;
        acc(1, 0, 0, 3'd5, 16'h0, "R9");
        acc(0, 1, 0, 3'd5, 16'h00FE, "R9");
        strap_in = 8'h00;
        acc(1, 0, 1, 3'd5, 16'h0, "R9");
        // R11: unimplemented offsets
        acc(0, 1, 0, 3'd2, 16'h0055, "R11");
        acc(0, 1, 0, 3'd4, 16'h0077, "R11");
        acc(0, 1, 0, 3'd7, 16'h0099, "R11");
        acc(1, 0, 0, 3'd2, 16'h0, "R11");
        acc(1, 0, 0, 3'd4, 16'h0, "R11");
        acc(1, 0, 0, 3'd7, 16'h0, "R11");
        acc(1, 0, 0, 3'd6, 16'h0, "R11");
        // R6: relock; word-sized 0x83 does not relock
        acc(0, 1, 1, 3'd2, 16'h0083, "R6");
        lockst("R6", 1);
        acc(0, 1, 0, 3'd2, 16'h0083, "R6");
        lockst("R6", 0);
        // R4: broken sequences
        acc(1, 0, 1, 3'd1, 0, "R4"); acc(0, 1, 0, 3'd4, 0, "R4");
        acc(0, 1, 0, 3'd2, 16'h0003, "R4"); lockst("R4", 0);
        acc(1, 0, 1, 3'd1, 0, "R4"); acc(1, 0, 1, 3'd1, 0, "R4");
        acc(0, 1, 1, 3'd2, 16'h0003, "R4"); lockst("R4", 0);
        acc(1, 0, 1, 3'd1, 0, "R4"); acc(1, 0, 1, 3'd1, 0, "R4");
        acc(0, 1, 0, 3'd2, 16'h0013, "R4"); lockst("R4", 0);
        acc(1, 0, 1, 3'd1, 0, "R4"); acc(1, 0, 0, 3'd1, 0, "R4");
        acc(0, 1, 0, 3'd2, 16'h0003, "R4"); lockst("R4", 0);
        acc(1, 0, 1, 3'd1, 0, "R4"); acc(1, 0, 1, 3'd1, 0, "R4");
        acc(1, 0, 1, 3'd1, 0, "R4"); repeat (3) @(posedge clk);
        acc(0, 1, 0, 3'd2, 16'h0003, "R4"); lockst("R4", 1);
        // R12: contents retained
        acc(1, 0, 0, 3'd0, 16'h0, "R12");
        acc(1, 0, 0, 3'd3, 16'h0, "R12");
        acc(0, 1, 0, 3'd2, 16'h0083, "R12");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [15:0] d;
            r = $urandom_range(0, 19);
            d = 16'($urandom);
            case ($urandom_range(0, 3))
                0: d[7:0] = 8'h03;
                1: d[7:0] = 8'h83;
                2: d[7:0] = 8'h85;
                default: ;
            endcase
            if (r == 0) unlock("R3");
            else if (r < 4) acc(1, 0, $urandom_range(0, 3) != 0, 3'd1, d, "R4");
            else if (r < 11) acc(1, 0, 1'($urandom), 3'($urandom), d, "R5");
            else acc(0, 1, 1'($urandom), 3'($urandom), d, "R8");
            if (r == 19) strap_in = 8'($urandom);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule